// File: doc/BRIEF.md
# Pseudorandom Byte Serializer for Link Self-Test

This block is a stimulus source for self-testing a serial link. An 8-bit maximal-length linear feedback shift register produces a pseudorandom byte. A parallel-in serial-out register sends that byte out one bit per accepted trigger. The same byte is also held on a parallel output, so one side of the link under test can take it as a word while the other side gets it as a bit stream.

A 3-bit down counter counts the accepted triggers. The eighth accepted trigger does three things: it steps the generator, it reloads the counter, and one clock later it raises a load strobe. The edge that ends the strobe moves the fresh byte into the shift register and onto the parallel output.

The data path has no valid/ready pair. The `hold` pin is the back-pressure signal: while it is high, the downstream side is not ready and every trigger is refused. This is done with clock enables, so all state keeps its value. A trigger that arrives during the strobe cycle is also refused, so the first bit of the new byte is never skipped.

Top module: `lfsr_byte_serializer`

## Requirements
- R1: After reset, `par_word` is 0x01, `ser_bit` is 1 (bit 0 of 0x01) and `load_strobe` is 0.
- R2: Each new byte is computed from the previous byte w as {w[6:0], w[7]^w[5]^w[4]^w[3]}.
- R3: The byte sequence never holds zero. Starting from 0x01, it passes through 255 distinct values and returns to 0x01 on the 255th new byte.
- R4: The current byte leaves least significant bit first. `ser_bit` shows bit k after k accepted triggers, and each accepted trigger advances it by exactly one bit.
- R5: `load_strobe` rises on the clock edge that takes the eighth accepted trigger of a byte and stays high for exactly one cycle. It stays low after the first seven triggers.
- R6: The edge that ends `load_strobe` puts the new byte on `par_word` and bit 0 of that byte on `ser_bit`. `par_word` changes at no other edge.
- R7: While `hold` is 1, `trig` is ignored: `ser_bit`, `par_word`, `load_strobe` and the bit position keep their values.
- R8: A trigger in the cycle where `load_strobe` is high is ignored. The next accepted trigger advances from bit 0 of the new byte.
- R9: The generator advances only on the eighth accepted trigger. During the first seven triggers of a byte, `par_word` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Bit advance request, taken once per cycle while high |
| hold | input | 1 | Downstream not ready; freezes all state |
| ser_bit | output | 1 | Current serial bit, least significant bit first |
| par_word | output | 8 | Current byte, for the parallel side |
| load_strobe | output | 1 | One-cycle pulse ahead of a byte reload |

## Verification
The serializer is driven in three ways. In the first, single trigger pulses are separated by idle cycles. In the second, `trig` is held high without a break, so a trigger also falls in every strobe cycle; this is the case where dropping or keeping that trigger makes the two results differ. In the third, `hold` is raised in the middle of a byte while triggers keep arriving, which separates a true freeze from a shift that is only delayed. A full run of 255 bytes, each one compared with the step rule and with every byte seen before it, tells a maximal-length generator apart from one with a wrong tap or a short cycle.

// File: rtl/lfsr_ser_pkg.sv
`timescale 1ns/1ps
package lfsr_ser_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] word_t;
  localparam word_t SEED     = 8'h01;
  localparam word_t TAP_MASK = 8'hB8;  // bits 7,5,4,3 feed back

  function automatic word_t lfsr_step(input word_t s);
    return {s[BYTE_W-2:0], ^(s & TAP_MASK)};
  endfunction
endpackage

// File: rtl/prs_lfsr.sv
`timescale 1ns/1ps
module prs_lfsr
  import lfsr_ser_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  output word_t state
);
  word_t st;

  always_ff @(posedge clk) begin
    if (!rst_n)   st <= SEED;
    else if (adv) st <= lfsr_step(st);
  end

  assign state = st;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);  // R3
  AST_LFSR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(st));  // R9
endmodule

// File: rtl/bit_down_counter.sv
`timescale 1ns/1ps
module bit_down_counter #(
  parameter int CW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic last,
  output logic strobe
);
  logic [CW-1:0] cnt;
  logic          strobe_q;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '1;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= step && last;
      if (step) cnt <= last ? '1 : cnt - 1'b1;
    end
  end

  assign strobe = strobe_q;

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);  // R5
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));  // R7
endmodule

// File: rtl/piso_shifter.sv
`timescale 1ns/1ps
module piso_shifter
  import lfsr_ser_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  shift,
  input  word_t din,
  output logic  ser,
  output word_t word
);
  word_t sreg;
  word_t word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg   <= SEED;
      word_q <= SEED;
    end else if (load) begin
      sreg   <= din;
      word_q <= din;
    end else if (shift) begin
      sreg <= {1'b0, sreg[BYTE_W-1:1]};
    end
  end

  assign ser  = sreg[0];
  assign word = word_q;

  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> ser == $past(sreg[1]));  // R4
  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> word == $past(din));  // R6
endmodule

// File: rtl/lfsr_byte_serializer.sv
`timescale 1ns/1ps
module lfsr_byte_serializer
  import lfsr_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              hold,
  output logic              ser_bit,
  output logic [BYTE_W-1:0] par_word,
  output logic              load_strobe
);
  logic  accept;
  logic  last_bit;
  logic  strobe;
  word_t gen_state;

  assign accept = trig && !hold && !strobe;

  bit_down_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(accept), .last(last_bit), .strobe(strobe)
  );

  prs_lfsr u_gen (
    .clk(clk), .rst_n(rst_n), .adv(accept && last_bit), .state(gen_state)
  );

  piso_shifter u_piso (
    .clk(clk), .rst_n(rst_n), .load(strobe), .shift(accept),
    .din(gen_state), .ser(ser_bit), .word(par_word)
  );

  assign load_strobe = strobe;

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load_strobe) |=> ($stable(ser_bit) && $stable(par_word)));  // R7
  AST_PAR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_strobe |=> $stable(par_word));  // R6
  AST_RELOAD_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> ser_bit == par_word[0]);  // R8
endmodule

// File: tb/lfsr_byte_serializer_test.sv
`timescale 1ns/1ps
module lfsr_byte_serializer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0;
  logic       hold = 1'b0;
  logic       ser_bit;
  logic [7:0] par_word;
  logic       load_strobe;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [7:0]  exp_w;
  logic [255:0] seen;
  int          bytes_done = 0;

  always #10 clk = ~clk;  // 50 MHz

  lfsr_byte_serializer uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .hold(hold),
    .ser_bit(ser_bit), .par_word(par_word), .load_strobe(load_strobe)
  );

  function automatic logic [7:0] model_next(input logic [7:0] w);
    return {w[6:0], w[7] ^ w[5] ^ w[4] ^ w[3]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Sends one byte; gap idle cycles between triggers, trigger kept high in strobe cycle.
  task automatic run_byte(input int gap, input bit final_ok);
    logic [7:0] nxt;
    nxt = model_next(exp_w);
    for (int i = 0; i < 8; i++) begin
      chk(ser_bit === exp_w[i], "R4 serial bit", ser_bit, exp_w[i]);
      if (i > 0) chk(par_word === exp_w, "R9 word steady mid-byte", par_word, exp_w);
      trig = 1'b1;
      @(negedge clk);
      if (i == 7) begin
        chk(load_strobe === 1'b1, "R5 strobe after eighth", load_strobe, 1);
        trig = 1'b1;  // R8: this trigger must be dropped
        @(negedge clk);
        trig = 1'b0;
      end else begin
        chk(load_strobe === 1'b0, "R5 no early strobe", load_strobe, 0);
        trig = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    chk(load_strobe === 1'b0, "R5 strobe one cycle", load_strobe, 0);
    chk(par_word === nxt, "R2 R6 new word", par_word, nxt);
    chk(ser_bit === nxt[0], "R8 bit0 kept", ser_bit, nxt[0]);
    chk(par_word !== 8'h00, "R3 nonzero", par_word, 1);
    if (final_ok) chk(nxt === 8'h01, "R3 back to seed", nxt, 1);
    else          chk(!seen[nxt], "R3 distinct", nxt, 0);
    seen[nxt] = 1'b1;
    exp_w = nxt;
    bytes_done++;
  endtask

  task automatic t_reset;
    chk(par_word === 8'h01, "R1 reset word", par_word, 1);
    chk(ser_bit === 1'b1, "R1 reset bit", ser_bit, 1);
    chk(load_strobe === 1'b0, "R1 reset strobe", load_strobe, 0);
  endtask

  task automatic t_hold;
    logic [7:0] nxt;
    nxt = model_next(exp_w);
    for (int i = 0; i < 3; i++) begin
      trig = 1'b1; @(negedge clk); trig = 1'b0;
    end
    hold = 1'b1; trig = 1'b1;
    repeat (6) @(negedge clk);
    chk(ser_bit === exp_w[3], "R7 bit frozen", ser_bit, exp_w[3]);
    chk(par_word === exp_w, "R7 word frozen", par_word, exp_w);
    chk(load_strobe === 1'b0, "R7 no strobe", load_strobe, 0);
    hold = 1'b0;
    for (int i = 3; i < 8; i++) begin
      chk(ser_bit === exp_w[i], "R7 resume bit", ser_bit, exp_w[i]);
      @(negedge clk);
    end
    chk(load_strobe === 1'b1, "R7 strobe after resume", load_strobe, 1);
    trig = 1'b0;
    @(negedge clk);
    chk(par_word === nxt, "R7 word after resume", par_word, nxt);
    seen[nxt] = 1'b1;
    exp_w = nxt;
    bytes_done++;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    seen = '0;
    seen[8'h01] = 1'b1;
    exp_w = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_byte(2, 1'b0);
    run_byte(0, 1'b0);
    run_byte(0, 1'b0);
    t_hold();
    while (bytes_done < 254) run_byte(0, 1'b0);
    run_byte(0, 1'b1);  // 255th new byte, R3
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule